// File: doc/BRIEF.md
# Global Alignment Traceback Walker

This block recovers one optimal global alignment of two nucleotide strings once the scoring array has finished. While the array scores the grid, it writes one predecessor move per interior cell into the block's move store (diagonal, from above, or from the left). When the array signals completion with a start pulse, the walker begins at the bottom-right cell and follows the stored moves back to the top-left corner.

Each step emits one alignment column: a symbol or a gap for the first string, and a symbol or a gap for the second. The columns come out in reverse order, so the last column of the alignment appears first. On the top border row and the left border column the walker ignores the store and forces gap moves. The output is a valid/ready stream. A low ready pauses the walk, and no column is lost.

Top module: `align_trace`

## Requirements
- R1: During and after reset `out_valid` and `out_last` are 0.
- R2: A write with `dir_we`=1 stores `dir_val` as the move for cell (`dir_row`,`dir_col`), rows and columns 1..LEN. Move codes: 0 diagonal, 1 from above, 2 from the left. Code 3 acts as diagonal.
- R3: A `walk_start` pulse while idle latches both strings and starts the walk at cell (LEN,LEN). The first column emitted comes from that cell's stored move. Symbol k of a string sits at bits [2k+1:2k], coded A=0, C=1, G=2, T=3.
- R4: A diagonal move at (r,c) emits symbol c-1 of string A and symbol r-1 of string B, both gap flags 0. It then moves to (r-1,c-1).
- R5: A move from above at (r,c) emits `out_a_gap`=1 with `out_a_sym`=0, and symbol r-1 of string B. It then moves to (r-1,c).
- R6: A move from the left at (r,c) emits symbol c-1 of string A, and `out_b_gap`=1 with `out_b_sym`=0. It then moves to (r,c-1).
- R7: On row 0 every move is from the left, and on column 0 every move is from above, whatever the store holds.
- R8: `out_last` is 1 only on the column that reaches (0,0). A walk emits between LEN and 2*LEN columns.
- R9: While `out_valid`=1 and `out_ready`=0, all outputs hold their values. Every column is delivered exactly once.
- R10: A `walk_start` pulse during a walk has no effect on the emitted stream.
- R11: With `out_ready` held at 1, the walk emits one column per clock from first to last.
- R12: For strings whose moves come from the match +1 / mismatch -1 / gap -1 recurrence, the emitted columns score to the optimal global score.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_we | input | 1 | Move store write enable |
| dir_row | input | $clog2(LEN+1) | Row of the cell written (1..LEN) |
| dir_col | input | $clog2(LEN+1) | Column of the cell written (1..LEN) |
| dir_val | input | 2 | Predecessor move code |
| walk_start | input | 1 | Scoring done, begin the walk |
| seq_a | input | 2*LEN | String A (columns), 2 bits per symbol |
| seq_b | input | 2*LEN | String B (rows), 2 bits per symbol |
| out_ready | input | 1 | Downstream accepts a column |
| out_valid | output | 1 | Column present |
| out_a_sym | output | 2 | String A symbol (0 when gap) |
| out_a_gap | output | 1 | String A has a gap in this column |
| out_b_sym | output | 2 | String B symbol (0 when gap) |
| out_b_gap | output | 1 | String B has a gap in this column |
| out_last | output | 1 | Column that reaches the corner |

## Verification
A wrong position register or a stale move read shows up in the very next accepted column as a wrong symbol or gap pattern. From there the column sequence diverges from the scoreboard, and the column count and alignment score drift as well. A stall bug shows up in the cycle after ready drops, as an output that changes while it is held, or as a dropped or duplicated column. A fault in the border forcing or in end detection shows as a missing or early `out_last`, or as a column count outside LEN..2*LEN.

// File: rtl/align_trace_pkg.sv
package align_trace_pkg;
  typedef enum logic [1:0] {
    MV_DIAG = 2'd0,
    MV_UP   = 2'd1,
    MV_LEFT = 2'd2
  } move_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_WALK  = 2'd2
  } walk_st_t;
endpackage

// File: rtl/move_store.sv
module move_store #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [1:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [1:0] mem [DEPTH];

  // single write port, registered read: maps to one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_step.sv
module trace_step
  import align_trace_pkg::*;
#(
  parameter int LEN = 16,
  parameter int IW  = $clog2(LEN + 1)
) (
  input  logic [IW-1:0]    row,
  input  logic [IW-1:0]    col,
  input  logic [1:0]       stored,
  input  logic [2*LEN-1:0] str_a,
  input  logic [2*LEN-1:0] str_b,
  output logic [IW-1:0]    nrow,
  output logic [IW-1:0]    ncol,
  output logic [1:0]       a_sym,
  output logic             a_gap,
  output logic [1:0]       b_sym,
  output logic             b_gap,
  output logic             at_end
);
  move_t        mv;
  logic [IW-1:0] ai, bi;
  logic [1:0]   a_chr, b_chr;

  assign ai    = (col == '0) ? '0 : col - 1'b1;
  assign bi    = (row == '0) ? '0 : row - 1'b1;
  assign a_chr = str_a[2*ai +: 2];
  assign b_chr = str_b[2*bi +: 2];

  // borders force gap moves; interior follows the stored move
  always_comb begin
    if (row == '0)                mv = MV_LEFT;
    else if (col == '0)           mv = MV_UP;
    else if (stored == 2'd1)      mv = MV_UP;
    else if (stored == 2'd2)      mv = MV_LEFT;
    else                          mv = MV_DIAG;
  end

  always_comb begin
    nrow  = row;
    ncol  = col;
    a_sym = 2'd0;
    a_gap = 1'b1;
    b_sym = 2'd0;
    b_gap = 1'b1;
    unique case (mv)
      MV_DIAG: begin
        nrow = row - 1'b1; ncol = col - 1'b1;
        a_sym = a_chr; a_gap = 1'b0;
        b_sym = b_chr; b_gap = 1'b0;
      end
      MV_UP: begin
        nrow = row - 1'b1;
        b_sym = b_chr; b_gap = 1'b0;
      end
      default: begin
        ncol = col - 1'b1;
        a_sym = a_chr; a_gap = 1'b0;
      end
    endcase
  end

  assign at_end = (nrow == '0) && (ncol == '0);
endmodule

// File: rtl/align_trace.sv
module align_trace
  import align_trace_pkg::*;
#(
  parameter int LEN = 16,
  localparam int IW = $clog2(LEN + 1),
  localparam int AW = 2 * IW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_we,
  input  logic [IW-1:0]    dir_row,
  input  logic [IW-1:0]    dir_col,
  input  logic [1:0]       dir_val,
  input  logic             walk_start,
  input  logic [2*LEN-1:0] seq_a,
  input  logic [2*LEN-1:0] seq_b,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [1:0]       out_a_sym,
  output logic             out_a_gap,
  output logic [1:0]       out_b_sym,
  output logic             out_b_gap,
  output logic             out_last
);
  localparam logic [IW-1:0] LEN_I = IW'(LEN);

  walk_st_t         st;
  logic [IW-1:0]    row, col, nrow, ncol;
  logic [2*LEN-1:0] a_reg, b_reg;
  logic [1:0]       stored, s_a_sym, s_b_sym;
  logic             s_a_gap, s_b_gap, s_end;
  logic             advance;
  logic [AW-1:0]    waddr, raddr;

  // cell (r,c) for r,c in 1..LEN lives at {r-1, c-1}
  assign waddr   = {dir_row - 1'b1, dir_col - 1'b1};
  assign advance = (st == ST_WALK) && (!out_valid || out_ready);
  // while holding, re-read the current cell so its move stays available
  assign raddr   = advance ? {nrow - 1'b1, ncol - 1'b1} : {row - 1'b1, col - 1'b1};

  move_store #(.AW(AW)) u_store (
    .clk   (clk),
    .we    (dir_we),
    .waddr (waddr),
    .wdata (dir_val),
    .raddr (raddr),
    .rdata (stored)
  );

  trace_step #(.LEN(LEN), .IW(IW)) u_step (
    .row    (row),
    .col    (col),
    .stored (stored),
    .str_a  (a_reg),
    .str_b  (b_reg),
    .nrow   (nrow),
    .ncol   (ncol),
    .a_sym  (s_a_sym),
    .a_gap  (s_a_gap),
    .b_sym  (s_b_sym),
    .b_gap  (s_b_gap),
    .at_end (s_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      row       <= '0;
      col       <= '0;
      a_reg     <= '0;
      b_reg     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_a_sym <= '0;
      out_a_gap <= 1'b0;
      out_b_sym <= '0;
      out_b_gap <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (walk_start) begin
          row   <= LEN_I;
          col   <= LEN_I;
          a_reg <= seq_a;
          b_reg <= seq_b;
          st    <= ST_PRIME;
        end
        ST_PRIME: st <= ST_WALK;
        default: if (advance) begin
          row <= nrow;
          col <= ncol;
          if (s_end) st <= ST_IDLE;
        end
      endcase

      if (advance) begin
        out_valid <= 1'b1;
        out_last  <= s_end;
        out_a_sym <= s_a_sym;
        out_a_gap <= s_a_gap;
        out_b_sym <= s_b_sym;
        out_b_gap <= s_b_gap;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [IW+1:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (rst)                                beat_cnt <= '0;
    else if (st == ST_IDLE && walk_start)   beat_cnt <= '0;
    else if (advance)                       beat_cnt <= beat_cnt + 1'b1;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a_sym) && $stable(out_a_gap)
                                   && $stable(out_b_sym) && $stable(out_b_gap) && $stable(out_last)));

  p_one_gap_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_a_gap && out_b_gap));

  p_beat_bound_r8: assert property (@(posedge clk) disable iff (rst)
    beat_cnt <= (IW+2)'(2*LEN));

  p_last_corner_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (row == '0 && col == '0));

  p_progress_r7: assert property (@(posedge clk) disable iff (rst)
    advance |=> (row <= $past(row) && col <= $past(col)
                 && (row != $past(row) || col != $past(col))));

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

// File: tb/test_align_trace.sv
`timescale 1ns/1ps
module test_align_trace;
  localparam int L  = 10;
  localparam int IW = $clog2(L + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_we = 1'b0;
  logic [IW-1:0] dir_row = '0, dir_col = '0;
  logic [1:0] dir_val = '0;
  logic walk_start = 1'b0;
  logic [2*L-1:0] seq_a = '0, seq_b = '0;
  logic out_ready = 1'b1;
  logic out_valid, out_a_gap, out_b_gap, out_last;
  logic [1:0] out_a_sym, out_b_sym;

  always #2 clk = ~clk;

  align_trace #(.LEN(L)) i_align_trace (
    .clk(clk), .rst(rst), .dir_we(dir_we), .dir_row(dir_row), .dir_col(dir_col),
    .dir_val(dir_val), .walk_start(walk_start), .seq_a(seq_a), .seq_b(seq_b),
    .out_ready(out_ready), .out_valid(out_valid), .out_a_sym(out_a_sym),
    .out_a_gap(out_a_gap), .out_b_sym(out_b_sym), .out_b_gap(out_b_gap),
    .out_last(out_last)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  int rdy_mode = 0;
  int sa [L], sb [L];
  int bdir [1:L][1:L];
  logic [6:0] exp_q [$];
  int seen = 0, last_seen = 0, score = 0, first_cyc = -1, last_cyc = 0;
  bit hold_prev = 0;
  logic [6:0] prev_out;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= (rdy_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    logic [6:0] cur;
    cur = {out_last, out_a_gap, out_a_sym, out_b_gap, out_b_sym};
    if (!rst) begin
      if (hold_prev) chk(out_valid && cur == prev_out, "R9 hold", int'(cur), int'(prev_out));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R9 extra column", int'(cur), -1);
        else begin
          logic [6:0] e;
          e = exp_q.pop_front();
          chk(cur == e, "R4/R5/R6/R7 column", int'(cur), int'(e));
        end
        if (first_cyc < 0) first_cyc = cyc;
        seen++;
        if (out_a_gap || out_b_gap || out_a_sym != out_b_sym) score--; else score++;
        if (out_last) begin last_seen++; last_cyc = cyc; end
      end
      hold_prev = out_valid && !out_ready;
      prev_out = cur;
    end
  end

  always @(posedge clk) if (cyc > 150000 && !finished) begin
    finished = 1;
    failures++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", last_seen, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int enc(byte c);
    case (c) "A": return 0; "C": return 1; "G": return 2; default: return 3; endcase
  endfunction

  task automatic set_strings(string a, string b);
    for (int k = 0; k < L; k++) begin
      sa[k] = enc(a[k]); sb[k] = enc(b[k]);
      seq_a[2*k +: 2] = 2'(sa[k]);
      seq_b[2*k +: 2] = 2'(sb[k]);
    end
  endtask

  // fill move map from the +1/-1/-1 recurrence, diag > up > left on ties
  task automatic score_dirs(output int best);
    int g [0:L][0:L];
    for (int i = 0; i <= L; i++) g[i][0] = -i;
    for (int j = 0; j <= L; j++) g[0][j] = -j;
    for (int i = 1; i <= L; i++)
      for (int j = 1; j <= L; j++) begin
        int d, u, l, m;
        d = g[i-1][j-1] + ((sa[j-1] == sb[i-1]) ? 1 : -1);
        u = g[i-1][j] - 1;
        l = g[i][j-1] - 1;
        m = d; if (u > m) m = u; if (l > m) m = l;
        g[i][j] = m;
        bdir[i][j] = (d == m) ? 0 : (u == m) ? 1 : 2;
      end
    best = g[L][L];
  endtask

  task automatic fill_dirs(int v);
    for (int i = 1; i <= L; i++)
      for (int j = 1; j <= L; j++) bdir[i][j] = v;
  endtask

  task automatic write_dirs();
    for (int i = 1; i <= L; i++)
      for (int j = 1; j <= L; j++) begin
        @(negedge clk);
        dir_we = 1; dir_row = IW'(i); dir_col = IW'(j); dir_val = 2'(bdir[i][j]);
      end
    @(negedge clk) dir_we = 0;
  endtask

  task automatic build_expected(output int n);
    int i = L, j = L, mv;
    n = 0;
    while (!(i == 0 && j == 0)) begin
      logic [6:0] e;
      mv = (i == 0) ? 2 : (j == 0) ? 1 : (bdir[i][j] == 3 ? 0 : bdir[i][j]);
      if (mv == 0)      begin e = {1'b0, 1'b0, 2'(sa[j-1]), 1'b0, 2'(sb[i-1])}; i--; j--; end
      else if (mv == 1) begin e = {1'b0, 1'b1, 2'd0, 1'b0, 2'(sb[i-1])}; i--; end
      else              begin e = {1'b0, 1'b0, 2'(sa[j-1]), 1'b1, 2'd0}; j--; end
      e[6] = (i == 0 && j == 0);
      exp_q.push_back(e);
      n++;
    end
  endtask

  task automatic run_walk(string tag, bit restart, int exp_score, bit chk_score);
    int n, base_seen, base_last;
    build_expected(n);
    base_seen = seen; base_last = last_seen; score = 0; first_cyc = -1;
    @(negedge clk) walk_start = 1;
    @(negedge clk) walk_start = 0;
    if (restart) begin // R10: second pulse mid-walk
      repeat (4) @(negedge clk);
      walk_start = 1;
      @(negedge clk) walk_start = 0;
    end
    wait (last_seen == base_last + 1);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, {"R8 queue drained ", tag}, exp_q.size(), 0);
    chk(seen - base_seen == n, {"R8/R10 column count ", tag}, seen - base_seen, n);
    chk(n >= L && n <= 2*L, {"R8 length bound ", tag}, n, L);
    chk(last_seen == base_last + 1, {"R10 single last ", tag}, last_seen - base_last, 1);
    if (chk_score) chk(score == exp_score, {"R12 score ", tag}, score, exp_score);
    if (rdy_mode == 0) chk(last_cyc - first_cyc == n - 1, {"R11 one per clock ", tag},
                           last_cyc - first_cyc, n - 1);
  endtask

  initial begin
    int best;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_last == 0, "R1 reset", int'(out_valid), 0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1 after reset", int'(out_valid), 0);

    // R3 R12: worked example, ready always high
    set_strings("ACGTTGCAGG", "GTTGCAGGAT");
    score_dirs(best);
    chk(best == 4, "R12 reference score", best, 4);
    write_dirs();
    rdy_mode = 0;
    run_walk("example", 0, 4, 1);

    // R4 R10: identical strings, all diagonal, random stalls, restart pulse
    set_strings("ACGTACGTAC", "ACGTACGTAC");
    score_dirs(best);
    write_dirs();
    rdy_mode = 1;
    run_walk("identical", 1, best, 1);

    // R2 R6 R7: map all from-left, then forced up along column 0
    fill_dirs(2);
    write_dirs();
    rdy_mode = 1;
    run_walk("all-left", 0, 0, 0);

    // R2 R5 R7: map all from-above, then forced left along row 0
    fill_dirs(1);
    write_dirs();
    rdy_mode = 0;
    run_walk("all-up", 0, 0, 0);

    // R2: code 3 acts as diagonal
    fill_dirs(3);
    write_dirs();
    run_walk("code3", 0, 0, 0);

    // R9 R12: full mismatch strings under random stalls
    set_strings("AAAAAAAAAA", "TTTTTTTTTT");
    score_dirs(best);
    write_dirs();
    rdy_mode = 1;
    run_walk("mismatch", 0, best, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule